// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time-of-Day Timer

This block keeps a 64-bit nanosecond time of day for precision time protocol use. It runs on a fast timer oscillator. Each oscillator cycle, a 32-bit phase accumulator adds a programmed addend. Every carry out of that accumulator is one nominal tick. On each tick the time counter advances by the programmed nominal period in nanoseconds.

The fine frequency comes from the addend. For an oscillator-to-nominal ratio R greater than 1, the addend is ceil(2^32 / R). As an example, an addend of 0x999999A4 gives one tick per roughly 1.6667 oscillator cycles.

A prescaler divides the tick rate to form a slower output clock. Two identical interval generators each count elapsed nanoseconds and emit a pulse one output-clock period wide. Each interval register is programmed as the desired interval minus one nominal period. With a 10 ns period, 999,999,990 gives one pulse per second. Each pulse sets a sticky event flag, and software clears the flag by writing a one to it.

Configuration arrives over a plain single-cycle write port. There is no streaming data path, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `ptp_tod_timer`

## Requirements
- R1: After reset, the time output is 0, all pulse and event outputs are 0, the block is disabled, and all configuration registers hold 0.
- R2: While enabled, each clock cycle adds the addend to a 32-bit accumulator that starts at 0. Each carry out adds the period register to the time. After n enabled cycles at addend A, the time equals period × floor(n·A / 2^32).
- R3: While bit 0 of the control register (address 0) is 0, the accumulator, the time, the prescaler and the interval generators all hold their values. Enabling again resumes from the held accumulator phase.
- R4: A write to the addend register (address 2) is used from the cycle after the write. The write clears neither the accumulator nor the time.
- R5: With a prescale register value P of 2 or more (address 4; 0 acts as 1), the output clock has a period of P ticks. It is high for the first ceil(P/2) ticks of each period.
- R6: An interval generator whose register (address 5 + index) holds (N−1) × period fires on every N-th tick. The first firing after a reset falls on the N-th tick after enabling.
- R7: Each firing drives that generator's pulse output high for max(P,1) ticks, starting at the firing tick.
- R8: Each firing sets that generator's event flag. The flag stays set until a write to address 1 with a 1 in that generator's bit. A 0 bit leaves the flag unchanged.
- R9: The two generators run independently from their own interval registers, and each drives its own pulse and event outputs.
- R10: The period register is at address 3. A write to an unmapped address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| time_ns | output | 64 | Nanosecond time of day |
| out_clk | output | 1 | Prescaled output clock |
| pulse | output | 2 | Interval generator pulses, one bit per generator |
| irq | output | 2 | Sticky event flags, one bit per generator |

## Verification
The hardest case to reach from the ports is the carry-phase relation of the accumulator across an addend change and across a disable/enable pair. Neither the accumulator nor its carries are visible at the ports.

To reach it, the bench writes the new addend, or toggles enable, mid-run at a chosen cycle. It then compares the time against a closed-form tick count. That count carries the old accumulator phase forward, so a reset accumulator or a lost cycle changes the tick total.

The bench also sweeps the interval divisor and the prescale value over a small range, using an addend of one half. With that addend, pulse spacing and width map exactly onto clock cycles.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  // register address map
  localparam int unsigned ADR_CTRL     = 0;
  localparam int unsigned ADR_EVCLR    = 1;
  localparam int unsigned ADR_ADDEND   = 2;
  localparam int unsigned ADR_PERIOD   = 3;
  localparam int unsigned ADR_PRESCALE = 4;
  localparam int unsigned ADR_IVL0     = 5;
  // control register fields
  localparam int unsigned CTRL_EN_BIT  = 0;
endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
  import ptp_tmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int ACC_W  = 32,
  parameter int NS_W   = 8,
  parameter int PRSC_W = 16,
  parameter int IVL_W  = 32,
  parameter int N_GEN  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [ACC_W-1:0]            wr_data,
  output logic                        run_en,
  output logic [ACC_W-1:0]            addend,
  output logic [NS_W-1:0]             period,
  output logic [PRSC_W-1:0]           prescale,
  output logic [N_GEN-1:0][IVL_W-1:0] interval,
  output logic [N_GEN-1:0]            ev_clr
);
  logic sel_ctrl, sel_evclr, sel_add, sel_per, sel_prs;

  assign sel_ctrl  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign sel_evclr = wr_en && (wr_addr == ADDR_W'(ADR_EVCLR));
  assign sel_add   = wr_en && (wr_addr == ADDR_W'(ADR_ADDEND));
  assign sel_per   = wr_en && (wr_addr == ADDR_W'(ADR_PERIOD));
  assign sel_prs   = wr_en && (wr_addr == ADDR_W'(ADR_PRESCALE));

  // write-one-to-clear strobe, valid only in the write cycle
  assign ev_clr = sel_evclr ? wr_data[N_GEN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      addend   <= '0;
      period   <= '0;
      prescale <= '0;
    end else begin
      if (sel_ctrl) run_en   <= wr_data[CTRL_EN_BIT];
      if (sel_add)  addend   <= wr_data;
      if (sel_per)  period   <= wr_data[NS_W-1:0];
      if (sel_prs)  prescale <= wr_data[PRSC_W-1:0];
    end
  end

  for (genvar g = 0; g < N_GEN; g++) begin : g_ivl
    logic sel_ivl;
    assign sel_ivl = wr_en && (wr_addr == ADDR_W'(ADR_IVL0 + g));
    always_ff @(posedge clk) begin
      if (!rst_n)       interval[g] <= '0;
      else if (sel_ivl) interval[g] <= wr_data[IVL_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [ACC_W-1:0] addend,
  output logic             tick
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, phase_q} + {1'b0, addend};
  // a carry out of the phase word is one nominal tick
  assign tick = run_en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (run_en) phase_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ptp_tod_count.sv
module ptp_tod_count #(
  parameter int TIME_W = 64,
  parameter int NS_W   = 8,
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NS_W-1:0]   period,
  input  logic [PRSC_W-1:0] prescale,
  output logic [TIME_W-1:0] time_ns,
  output logic              out_clk
);
  localparam int PW1 = PRSC_W + 1;

  logic [PRSC_W-1:0] div_eff;
  logic [PRSC_W-1:0] div_cnt_q;
  logic [PW1-1:0]    high_len;

  assign div_eff  = (prescale == '0) ? PRSC_W'(1) : prescale;
  assign high_len = ({1'b0, div_eff} + PW1'(1)) >> 1;
  assign out_clk  = ({1'b0, div_cnt_q} < high_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_ns <= '0;
    end else if (tick) begin
      time_ns <= time_ns + {{(TIME_W-NS_W){1'b0}}, period};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
    end else if (tick) begin
      if (div_cnt_q >= div_eff - PRSC_W'(1)) div_cnt_q <= '0;
      else                                   div_cnt_q <= div_cnt_q + PRSC_W'(1);
    end
  end
endmodule

// File: rtl/ptp_ivl_gen.sv
module ptp_ivl_gen #(
  parameter int IVL_W  = 32,
  parameter int NS_W   = 8,
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NS_W-1:0]   period,
  input  logic [IVL_W-1:0]  interval,
  input  logic [PRSC_W-1:0] prescale,
  input  logic              clr,
  output logic              pulse,
  output logic              irq
);
  localparam int EL_W = IVL_W + 2;

  logic [EL_W-1:0]   elapsed_q;
  logic [EL_W-1:0]   step;
  logic [EL_W-1:0]   target;
  logic [PRSC_W-1:0] width_q;
  logic [PRSC_W-1:0] width_eff;
  logic              fire;

  // the register holds interval minus one tick; add the tick back
  assign step      = elapsed_q + EL_W'(period);
  assign target    = EL_W'(interval) + EL_W'(period);
  assign fire      = tick && (step >= target);
  assign width_eff = (prescale == '0) ? PRSC_W'(1) : prescale;
  assign pulse     = (width_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (fire) begin
      // keep the remainder so pulses stay on the tick grid
      elapsed_q <= step - target;
    end else if (tick) begin
      elapsed_q <= step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= '0;
    end else if (fire) begin
      width_q <= width_eff;
    end else if (tick && width_q != '0) begin
      width_q <= width_q - PRSC_W'(1);
    end
  end

  // sticky flag: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (fire) irq <= 1'b1;
    else if (clr)  irq <= 1'b0;
  end
endmodule

// File: rtl/ptp_tod_timer.sv
module ptp_tod_timer #(
  parameter int ADDR_W = 4,
  parameter int ACC_W  = 32,
  parameter int TIME_W = 64,
  parameter int NS_W   = 8,
  parameter int PRSC_W = 16,
  parameter int IVL_W  = 32,
  parameter int N_GEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              out_clk,
  output logic [N_GEN-1:0]  pulse,
  output logic [N_GEN-1:0]  irq
);
  logic                        run_en;
  logic                        tick;
  logic [ACC_W-1:0]            addend_q;
  logic [NS_W-1:0]             period_q;
  logic [PRSC_W-1:0]           prescale_q;
  logic [N_GEN-1:0][IVL_W-1:0] interval_q;
  logic [N_GEN-1:0]            ev_clr;

  ptp_cfg_regs #(
    .ADDR_W(ADDR_W), .ACC_W(ACC_W), .NS_W(NS_W),
    .PRSC_W(PRSC_W), .IVL_W(IVL_W), .N_GEN(N_GEN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_en(run_en), .addend(addend_q), .period(period_q),
    .prescale(prescale_q), .interval(interval_q), .ev_clr(ev_clr)
  );

  ptp_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .addend(addend_q), .tick(tick)
  );

  ptp_tod_count #(.TIME_W(TIME_W), .NS_W(NS_W), .PRSC_W(PRSC_W)) u_tod (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period_q),
    .prescale(prescale_q), .time_ns(time_ns), .out_clk(out_clk)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    ptp_ivl_gen #(.IVL_W(IVL_W), .NS_W(NS_W), .PRSC_W(PRSC_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .period(period_q),
      .interval(interval_q[g]), .prescale(prescale_q),
      .clr(ev_clr[g]), .pulse(pulse[g]), .irq(irq[g])
    );
  end
endmodule

// File: rtl/ptp_tod_timer_chk.sv
module ptp_tod_timer_chk #(
  parameter int TIME_W = 64,
  parameter int NS_W   = 8,
  parameter int N_GEN  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              tick,
  input logic [NS_W-1:0]   period,
  input logic [TIME_W-1:0] time_ns,
  input logic [N_GEN-1:0]  pulse,
  input logic [N_GEN-1:0]  irq,
  input logic [N_GEN-1:0]  ev_clr
);
  // R2: time moves only by one period per cycle, and only on a tick
  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_ns == $past(time_ns) + {{(TIME_W-NS_W){1'b0}}, $past(period)}));

  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_ns));

  // R3: disabled means no ticks
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick);

  for (genvar g = 0; g < N_GEN; g++) begin : g_chk
    // R8: flag holds until a clear bit
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[g] && !ev_clr[g]) |=> irq[g]);
    // R8: a pulse start always flags an event
    p_pulse_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[g]) |-> irq[g]);
    // R6: pulses start only on a tick
    p_pulse_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[g]) |-> $past(tick));
  end
endmodule

bind ptp_tod_timer ptp_tod_timer_chk #(
  .TIME_W(TIME_W), .NS_W(NS_W), .N_GEN(N_GEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
  .period(period_q), .time_ns(time_ns), .pulse(pulse),
  .irq(irq), .ev_clr(ev_clr)
);

// File: tb/ptp_tod_timer_test.sv
module ptp_tod_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_ns;
  logic        out_clk;
  logic [1:0]  pulse;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_tod_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .time_ns(time_ns), .out_clk(out_clk),
    .pulse(pulse), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] a, input int per, input int prs,
                       input int iv0, input int iv1);
    do_reset();
    wr(2, a); wr(3, 32'(per)); wr(4, 32'(prs)); wr(5, 32'(iv0)); wr(6, 32'(iv1));
  endtask

  function automatic logic sig(input int sel);
    return (sel < 2) ? pulse[sel] : out_clk;
  endfunction

  // cycles between two rising edges and high samples in that span
  task automatic spacing(input int sel, output int gap, output int hi);
    logic prev, cur;
    bit found;
    int n;
    prev = sig(sel); found = 0; n = 0;
    while (!found && n < 2000) begin
      @(negedge clk); cur = sig(sel); found = (!prev && cur); prev = cur; n++;
    end
    gap = 0; hi = 1; found = 0;
    while (!found && gap < 2000) begin
      @(negedge clk); cur = sig(sel); gap++; found = (!prev && cur);
      if (cur && !found) hi++;
      prev = cur;
    end
  endtask

  function automatic longint unsigned ticks_of(input longint unsigned phase_sum);
    return phase_sum >> 32;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] adds [6];
    int pers [6];
    int gap, hi;
    longint unsigned exp_t;
    adds = '{32'h4000_0000, 32'h9999_99A4, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0100_0000};
    pers = '{10, 10, 1, 255, 7, 3};

    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(time_ns == 0, "R1 time after reset", longint'(time_ns), 0);
    chk(pulse == 0 && irq == 0, "R1 pulse/irq after reset", longint'({pulse, irq}), 0);
    run(20);
    chk(time_ns == 0, "R1 disabled after reset", longint'(time_ns), 0);

    // R2 sweep of addend and period
    for (int i = 0; i < 6; i++) begin
      setup(adds[i], pers[i], 0, 0, 0);
      wr(0, 1);
      run(1000);
      exp_t = longint'(pers[i]) * ticks_of(64'd1000 * adds[i]);
      chk(time_ns == exp_t, $sformatf("R2 time addend=%h", adds[i]), longint'(time_ns), longint'(exp_t));
    end

    // R3 freeze and resume
    setup(32'h9999_99A4, 10, 0, 0, 0);
    wr(0, 1); run(50); wr(0, 0); run(40);
    exp_t = 10 * ticks_of(64'd51 * 32'h9999_99A4);
    chk(time_ns == exp_t, "R3 frozen time", longint'(time_ns), longint'(exp_t));
    wr(0, 1); run(60);
    exp_t = 10 * ticks_of(64'd111 * 32'h9999_99A4);
    chk(time_ns == exp_t, "R3 resumed phase", longint'(time_ns), longint'(exp_t));

    // R4 addend change keeps phase
    setup(32'h3000_0000, 10, 0, 0, 0);
    wr(0, 1); run(37); wr(2, 32'hC000_0001); run(53);
    exp_t = 10 * ticks_of(64'd38 * 32'h3000_0000 + 64'd53 * 32'hC000_0001);
    chk(time_ns == exp_t, "R4 addend change", longint'(time_ns), longint'(exp_t));

    // R10 unmapped write ignored
    setup(32'h4000_0000, 7, 0, 0, 0);
    wr(0, 1); run(20); wr(15, 32'hFFFF_FFFF); run(19);
    chk(time_ns == 70, "R10 unmapped write", longint'(time_ns), 70);

    // R5 output clock period and duty sweep
    for (int p = 2; p <= 6; p++) begin
      setup(32'h8000_0000, 10, p, 0, 0);
      wr(0, 1);
      spacing(2, gap, hi);
      chk(gap == 2 * p, $sformatf("R5 out_clk period P=%0d", p), gap, 2 * p);
      chk(hi == 2 * ((p + 1) / 2), $sformatf("R5 out_clk high P=%0d", p), hi, 2 * ((p + 1) / 2));
    end

    // R6/R7 interval divisor sweep, width one tick
    for (int n = 2; n <= 7; n++) begin
      setup(32'h8000_0000, 10, 1, (n - 1) * 10, 0);
      wr(0, 1);
      spacing(0, gap, hi);
      chk(gap == 2 * n, $sformatf("R6 spacing N=%0d", n), gap, 2 * n);
      chk(hi == 2, $sformatf("R7 width N=%0d", n), hi, 2);
    end

    // R6 first firing, R7 wider pulse, R9 independence, R8 flags
    setup(32'h8000_0000, 10, 2, 40, 20);
    wr(0, 1);
    run(9);
    chk(pulse[0] == 1'b0, "R6 before 5th tick", longint'(pulse[0]), 0);
    run(1);
    chk(pulse[0] == 1'b1, "R6 at 5th tick", longint'(pulse[0]), 1);
    chk(irq == 2'b11, "R8 flags set", longint'(irq), 3);
    spacing(0, gap, hi);
    chk(gap == 10 && hi == 4, "R7 width P=2 gen0", gap * 100 + hi, 1004);
    spacing(1, gap, hi);
    chk(gap == 6 && hi == 4, "R9 gen1 own interval", gap * 100 + hi, 604);
    wr(0, 0);
    wr(1, 0); run(2);
    chk(irq == 2'b11, "R8 zero clear no effect", longint'(irq), 3);
    wr(1, 1); run(2);
    chk(irq == 2'b10, "R8 clear gen0 only", longint'(irq), 2);
    wr(1, 2); run(2);
    chk(irq == 2'b00, "R8 clear gen1", longint'(irq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule